// File: doc/BRIEF.md
# Banked Data-Memory Access Unit with Indirect Pointers

This block sits between the core of a small 8-bit controller and its data memory. The core presents an 8-bit register-file address, a read enable, a write enable with write data, and single-bit set and clear requests with a bit index. The unit resolves that address to a physical location and returns the read value combinationally. On the next rising clock edge it commits the write or the bit update.

The unit owns three control registers: two memory pointers and a bank pointer. It also owns two banks of general-purpose RAM. Two addresses in the low control area have no storage. They are windows that forward the access to whatever location the matching pointer holds. The first window always lands in bank 0. The second window follows the bank pointer.

Control-area addresses are reached whatever the bank pointer says. Control addresses that this unit does not own are passed through a port to an external register file. Reserved and unused addresses read as zero and ignore writes.

Top module: `dmem_access_unit`

## Requirements
- R1: Address 01h is pointer P0, address 03h is pointer P1, and address 04h is the bank select. Each reads and writes directly, and each holds 00h after reset.
- R2: Only bit 0 of the bank select is stored. A read of 04h returns that bit in bit 0 and zeros in bits 7:1.
- R3: An access to address 00h is redirected to the address held in P0. If that target is general-purpose RAM, the access uses bank 0 whatever the bank select holds.
- R4: An access to address 02h is redirected to the address held in P1. If that target is general-purpose RAM, the access uses the bank given by bit 0 of the bank select.
- R5: When a redirected access targets 00h or 02h, the read returns 00h and the write or bit update changes no state.
- R6: Addresses 30h–3Fh and 80h–FFh read as 00h, and writes to them change no state.
- R7: Addresses 05h–2Fh, reached directly or through a pointer, are forwarded to the external register file whatever the bank select holds. The forwarding presents the resolved address on `sfr_addr`, asserts `sfr_wr` with the value to store, and returns `sfr_rdata` as the read data.
- R8: A direct access to 40h–7Fh reaches RAM in the bank selected by bit 0 of the bank select. The two banks are independent.
- R9: `bit_set` or `bit_clr` changes only the bit of the resolved location numbered by `bit_sel` (bit 0 is the LSB) and leaves the other bits unchanged. `core_wr` takes priority over both requests, and `bit_set` takes priority over `bit_clr`.
- R10: Read data is combinational from the current address and state. `core_rdata` is 00h whenever `core_rd` is low. Writes and bit updates take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_addr | input | 8 | Register-file address from the core |
| core_rd | input | 1 | Read enable |
| core_wr | input | 1 | Byte write enable |
| core_wdata | input | 8 | Byte write data |
| bit_set | input | 1 | Set one bit of the addressed location |
| bit_clr | input | 1 | Clear one bit of the addressed location |
| bit_sel | input | 3 | Bit index for set or clear |
| core_rdata | output | 8 | Read data (zero when not reading) |
| sfr_addr | output | 8 | Resolved address to the external register file |
| sfr_rd | output | 1 | Read strobe to the external register file |
| sfr_wr | output | 1 | Write strobe to the external register file |
| sfr_wdata | output | 8 | Value to store in the external register file |
| sfr_rdata | input | 8 | Read data from the external register file |

## Verification
A corrupted pointer or bank bit has no effect of its own until the core uses it. It shows up on the first read through a redirecting address, when `core_rdata` returns the wrong RAM word or the wrong bank. A lost write shows on the next read of that location, and a stray write to a pointer shows at once on a direct read of 01h, 03h or 04h. The bench keeps a behavioural model of both banks, the pointers and the external file, and compares read data and forwarding strobes in every cycle. Any divergence is therefore caught on the first access that touches the damaged state.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;
  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam int BANK_W  = 1;
  localparam int N_BANKS = 1 << BANK_W;

  localparam logic [AW-1:0] A_WIN0 = 8'h00;
  localparam logic [AW-1:0] A_PTR0 = 8'h01;
  localparam logic [AW-1:0] A_WIN1 = 8'h02;
  localparam logic [AW-1:0] A_PTR1 = 8'h03;
  localparam logic [AW-1:0] A_BSEL = 8'h04;

  typedef enum logic [2:0] {
    LK_NONE, LK_WIN, LK_PTR0, LK_PTR1, LK_BSEL, LK_EXT, LK_RAM
  } loc_kind_e;

  typedef struct packed {
    loc_kind_e         kind;
    logic [AW-1:0]     addr;
    logic [BANK_W-1:0] bank;
  } loc_t;
endpackage

// File: rtl/dmem_rst_sync.sv
`timescale 1ns/1ps
module dmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/dmem_decode.sv
`timescale 1ns/1ps
module dmem_decode
  import dmem_pkg::*;
#(
  parameter logic [AW-1:0] EXT_FIRST = 8'h05,
  parameter logic [AW-1:0] EXT_LAST  = 8'h2F,
  parameter logic [AW-1:0] RAM_FIRST = 8'h40,
  parameter logic [AW-1:0] RAM_LAST  = 8'h7F
) (
  input  logic [AW-1:0]     addr,
  input  logic [AW-1:0]     ptr0,
  input  logic [AW-1:0]     ptr1,
  input  logic [BANK_W-1:0] bsel,
  output loc_t              loc
);
  function automatic loc_kind_e classify(input logic [AW-1:0] a);
    loc_kind_e k;
    if (a == A_WIN0 || a == A_WIN1)            k = LK_WIN;
    else if (a == A_PTR0)                      k = LK_PTR0;
    else if (a == A_PTR1)                      k = LK_PTR1;
    else if (a == A_BSEL)                      k = LK_BSEL;
    else if (a >= EXT_FIRST && a <= EXT_LAST)  k = LK_EXT;
    else if (a >= RAM_FIRST && a <= RAM_LAST)  k = LK_RAM;
    else                                       k = LK_NONE;
    return k;
  endfunction

  logic              redirect;
  logic [AW-1:0]     eff_addr;
  logic [BANK_W-1:0] eff_bank;
  loc_kind_e         eff_kind;

  always_comb begin
    redirect = 1'b0;
    eff_addr = addr;
    eff_bank = bsel;
    if (addr == A_WIN0) begin
      redirect = 1'b1;
      eff_addr = ptr0;
      eff_bank = '0;
    end else if (addr == A_WIN1) begin
      redirect = 1'b1;
      eff_addr = ptr1;
      eff_bank = bsel;
    end
    eff_kind = classify(eff_addr);
    if (redirect && eff_kind == LK_WIN) eff_kind = LK_NONE;
  end

  assign loc = '{kind: eff_kind, addr: eff_addr, bank: eff_bank};
endmodule

// File: rtl/dmem_ptr_regs.sv
`timescale 1ns/1ps
module dmem_ptr_regs
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ptr0,
  input  logic              ld_ptr1,
  input  logic              ld_bsel,
  input  logic [DW-1:0]     ld_val,
  output logic [AW-1:0]     ptr0,
  output logic [AW-1:0]     ptr1,
  output logic [BANK_W-1:0] bsel
);
  logic [AW-1:0]     ptr0_d, ptr1_d;
  logic [BANK_W-1:0] bsel_d;

  always_comb begin
    ptr0_d = ptr0;
    ptr1_d = ptr1;
    bsel_d = bsel;
    if (ld_ptr0) ptr0_d = ld_val;
    if (ld_ptr1) ptr1_d = ld_val;
    if (ld_bsel) bsel_d = ld_val[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr0 <= '0;
      ptr1 <= '0;
      bsel <= '0;
    end else begin
      ptr0 <= ptr0_d;
      ptr1 <= ptr1_d;
      bsel <= bsel_d;
    end
  end
endmodule

// File: rtl/dmem_ram_bank.sv
`timescale 1ns/1ps
module dmem_ram_bank
  import dmem_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/dmem_access_unit.sv
`timescale 1ns/1ps
module dmem_access_unit
  import dmem_pkg::*;
#(
  parameter logic [AW-1:0] EXT_FIRST = 8'h05,
  parameter logic [AW-1:0] EXT_LAST  = 8'h2F,
  parameter logic [AW-1:0] RAM_FIRST = 8'h40,
  parameter int            RAM_WORDS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    core_addr,
  input  logic          core_rd,
  input  logic          core_wr,
  input  logic [7:0]    core_wdata,
  input  logic          bit_set,
  input  logic          bit_clr,
  input  logic [2:0]    bit_sel,
  output logic [7:0]    core_rdata,
  output logic [7:0]    sfr_addr,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [7:0]    sfr_wdata,
  input  logic [7:0]    sfr_rdata
);
  localparam int IW = $clog2(RAM_WORDS);
  localparam logic [AW-1:0] RAM_LAST = RAM_FIRST + AW'(RAM_WORDS - 1);

  logic              rst_n_q;
  logic [AW-1:0]     ptr0, ptr1;
  logic [BANK_W-1:0] bsel;
  loc_t              loc;
  logic [DW-1:0]     cur_val, new_val, bit_mask;
  logic              commit, bit_req;
  logic              ld_ptr0, ld_ptr1, ld_bsel;
  logic [IW-1:0]     ram_idx;
  logic [DW-1:0]     ram_rd [N_BANKS];
  logic [N_BANKS-1:0] bank_we;

  dmem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_q)
  );

  dmem_decode #(
    .EXT_FIRST(EXT_FIRST), .EXT_LAST(EXT_LAST),
    .RAM_FIRST(RAM_FIRST), .RAM_LAST(RAM_LAST)
  ) u_dec (
    .addr(core_addr), .ptr0(ptr0), .ptr1(ptr1), .bsel(bsel), .loc(loc)
  );

  assign ram_idx = IW'(loc.addr - RAM_FIRST);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_we[b] = commit && (loc.kind == LK_RAM) && (int'(loc.bank) == b);
    dmem_ram_bank #(.WORDS(RAM_WORDS)) u_ram (
      .clk(clk), .we(bank_we[b]), .idx(ram_idx),
      .wdata(new_val), .rdata(ram_rd[b])
    );
  end

  always_comb begin
    case (loc.kind)
      LK_PTR0: cur_val = ptr0;
      LK_PTR1: cur_val = ptr1;
      LK_BSEL: cur_val = {{(DW-BANK_W){1'b0}}, bsel};
      LK_EXT:  cur_val = sfr_rdata;
      LK_RAM:  cur_val = ram_rd[loc.bank];
      default: cur_val = '0;
    endcase
  end

  assign bit_mask = DW'(1) << bit_sel;
  assign bit_req  = bit_set || bit_clr;
  assign commit   = core_wr || bit_req;

  always_comb begin
    if (core_wr)      new_val = core_wdata;
    else if (bit_set) new_val = cur_val | bit_mask;
    else if (bit_clr) new_val = cur_val & ~bit_mask;
    else              new_val = cur_val;
  end

  assign ld_ptr0 = commit && (loc.kind == LK_PTR0);
  assign ld_ptr1 = commit && (loc.kind == LK_PTR1);
  assign ld_bsel = commit && (loc.kind == LK_BSEL);

  dmem_ptr_regs u_ptr (
    .clk(clk), .rst_n(rst_n_q),
    .ld_ptr0(ld_ptr0), .ld_ptr1(ld_ptr1), .ld_bsel(ld_bsel),
    .ld_val(new_val), .ptr0(ptr0), .ptr1(ptr1), .bsel(bsel)
  );

  assign core_rdata = core_rd ? cur_val : '0;
  assign sfr_addr   = loc.addr;
  assign sfr_rd     = (loc.kind == LK_EXT) && (core_rd || (bit_req && !core_wr));
  assign sfr_wr     = (loc.kind == LK_EXT) && commit;
  assign sfr_wdata  = new_val;

  AST_PTR0_LOAD: assert property (@(posedge clk) disable iff (!rst_n_q)
    (core_wr && loc.kind == LK_PTR0) |=> (ptr0 == $past(core_wdata))); // R1
  AST_BSEL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n_q)
    (core_rd && core_addr == A_BSEL) |-> (core_rdata[DW-1:1] == '0)); // R2
  AST_WIN0_BANK0: assert property (@(posedge clk) disable iff (!rst_n_q)
    (core_addr == A_WIN0 && loc.kind == LK_RAM) |-> (loc.bank == '0)); // R3
  AST_WIN1_BANK: assert property (@(posedge clk) disable iff (!rst_n_q)
    (core_addr == A_WIN1 && loc.kind == LK_RAM) |-> (loc.bank == bsel)); // R4
  AST_VOID_HOLD: assert property (@(posedge clk) disable iff (!rst_n_q)
    (commit && loc.kind == LK_NONE) |=> ($stable(ptr0) && $stable(ptr1) && $stable(bsel))); // R5
  AST_VOID_ZERO: assert property (@(posedge clk) disable iff (!rst_n_q)
    (core_rd && loc.kind == LK_NONE) |-> (core_rdata == '0)); // R6
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n_q)
    $onehot0({ld_ptr0, ld_ptr1, ld_bsel, sfr_wr, bank_we})); // R7
  AST_BIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n_q)
    (!core_wr && bit_req && loc.kind == LK_PTR1) |=> (((ptr1 ^ $past(ptr1)) & ~$past(bit_mask)) == '0)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_q)
    (!core_rd) |-> (core_rdata == '0)); // R10
endmodule

// File: tb/dmem_access_unit_tb_top.sv
`timescale 1ns/1ps
module dmem_access_unit_tb_top;
  localparam int WD_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] core_addr, core_wdata, core_rdata;
  logic       core_rd, core_wr, bit_set, bit_clr;
  logic [2:0] bit_sel;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_rd, sfr_wr;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  dmem_access_unit dut_i (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_rd(core_rd),
    .core_wr(core_wr), .core_wdata(core_wdata), .bit_set(bit_set),
    .bit_clr(bit_clr), .bit_sel(bit_sel), .core_rdata(core_rdata),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // External register file stand-in
  logic [7:0] ext_mem [256];
  assign sfr_rdata = ext_mem[sfr_addr];
  always @(posedge clk) if (sfr_wr) ext_mem[sfr_addr] <= sfr_wdata;

  // Reference model state
  logic [7:0] m_b0 [64];
  logic [7:0] m_b1 [64];
  logic [7:0] m_ext [256];
  logic [7:0] m_p0, m_p1;
  logic       m_bs;

  function automatic logic [7:0] m_get(input int a, input int bk);
    if (a == 1) return m_p0;
    if (a == 3) return m_p1;
    if (a == 4) return {7'b0, m_bs};
    if (a >= 5 && a <= 'h2F) return m_ext[a];
    if (a >= 'h40 && a <= 'h7F) return (bk != 0) ? m_b1[a-'h40] : m_b0[a-'h40];
    return 8'h00;
  endfunction

  task automatic m_put(input int a, input int bk, input logic [7:0] v);
    if (a == 1) m_p0 = v;
    else if (a == 3) m_p1 = v;
    else if (a == 4) m_bs = v[0];
    else if (a >= 5 && a <= 'h2F) m_ext[a] = v;
    else if (a >= 'h40 && a <= 'h7F) begin
      if (bk != 0) m_b1[a-'h40] = v; else m_b0[a-'h40] = v;
    end
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] a, input bit rd, input bit wr, input logic [7:0] wd,
                    input bit s, input bit c, input logic [2:0] bs, input string tag);
    int ea, bk;
    bit void_acc, is_ext, cm;
    logic [7:0] cur, nv;
    @(negedge clk);
    core_addr = a; core_rd = rd; core_wr = wr; core_wdata = wd;
    bit_set = s; bit_clr = c; bit_sel = bs;
    #1;
    ea = a; bk = m_bs; void_acc = 0;
    if (a == 8'h00) begin ea = m_p0; bk = 0; end
    else if (a == 8'h02) begin ea = m_p1; bk = m_bs; end
    if ((a == 8'h00 || a == 8'h02) && (ea == 0 || ea == 2)) void_acc = 1;
    cur = void_acc ? 8'h00 : m_get(ea, bk);
    cm = wr || s || c;
    if (wr) nv = wd;
    else if (s) nv = cur | (8'h01 << bs);
    else if (c) nv = cur & ~(8'h01 << bs);
    else nv = cur;
    is_ext = !void_acc && ea >= 5 && ea <= 'h2F;
    check(core_rdata, rd ? cur : 8'h00, tag);
    check({7'b0, sfr_wr}, {7'b0, is_ext && cm}, tag);
    if (is_ext) check(sfr_addr, 8'(ea), tag);
    if (cm && !void_acc) m_put(ea, bk, nv);
  endtask

  task automatic rd_op(input logic [7:0] a, input string tag);
    op(a, 1, 0, 8'h00, 0, 0, 3'd0, tag);
  endtask
  task automatic wr_op(input logic [7:0] a, input logic [7:0] d, input string tag);
    op(a, 0, 1, d, 0, 0, 3'd0, tag);
  endtask

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ext_mem[i] = 8'(i ^ 8'h5A);
      m_ext[i]   = 8'(i ^ 8'h5A);
    end
    m_p0 = 8'h00; m_p1 = 8'h00; m_bs = 1'b0;
    core_addr = 8'h00; core_rd = 0; core_wr = 0; core_wdata = 8'h00;
    bit_set = 0; bit_clr = 0; bit_sel = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset values
    rd_op(8'h01, "R1"); rd_op(8'h03, "R1"); rd_op(8'h04, "R1");

    // R8 fill both banks
    wr_op(8'h04, 8'h00, "R1");
    for (int i = 'h40; i <= 'h7F; i++) wr_op(8'(i), 8'(i ^ 8'h33), "R8");
    wr_op(8'h04, 8'h01, "R1");
    for (int i = 'h40; i <= 'h7F; i++) wr_op(8'(i), 8'(i ^ 8'hC6), "R8");
    for (int i = 'h40; i <= 'h7F; i += 7) rd_op(8'(i), "R8");
    wr_op(8'h04, 8'h00, "R8");
    for (int i = 'h40; i <= 'h7F; i += 5) rd_op(8'(i), "R8");

    // R2 bank select width
    wr_op(8'h04, 8'hFF, "R2"); rd_op(8'h04, "R2");
    wr_op(8'h04, 8'hFE, "R2"); rd_op(8'h04, "R2");

    // R1 pointer read/write
    wr_op(8'h01, 8'h45, "R1"); rd_op(8'h01, "R1");
    wr_op(8'h03, 8'h45, "R1"); rd_op(8'h03, "R1");

    // R3 window 0 stays in bank 0
    wr_op(8'h04, 8'h01, "R3");
    rd_op(8'h00, "R3");
    wr_op(8'h00, 8'hA7, "R3");
    rd_op(8'h00, "R3");
    wr_op(8'h04, 8'h00, "R3"); rd_op(8'h45, "R3");
    wr_op(8'h04, 8'h01, "R3"); rd_op(8'h45, "R3");

    // R4 window 1 follows bank select
    rd_op(8'h02, "R4");
    wr_op(8'h02, 8'h3C, "R4");
    rd_op(8'h45, "R4");
    wr_op(8'h04, 8'h00, "R4");
    rd_op(8'h02, "R4");

    // R5 window onto a window
    wr_op(8'h01, 8'h00, "R5");
    rd_op(8'h00, "R5"); wr_op(8'h00, 8'hAA, "R5"); rd_op(8'h01, "R5");
    wr_op(8'h01, 8'h02, "R5");
    op(8'h00, 1, 0, 8'h00, 1, 0, 3'd4, "R5"); rd_op(8'h01, "R5");
    wr_op(8'h03, 8'h02, "R5");
    wr_op(8'h02, 8'h55, "R5"); rd_op(8'h03, "R5"); rd_op(8'h02, "R5");
    wr_op(8'h03, 8'h00, "R5");
    wr_op(8'h02, 8'h77, "R5"); rd_op(8'h03, "R5"); rd_op(8'h04, "R5");

    // R6 reserved and unused areas
    wr_op(8'h30, 8'h99, "R6"); rd_op(8'h30, "R6");
    wr_op(8'h3F, 8'h99, "R6"); rd_op(8'h3F, "R6");
    wr_op(8'h80, 8'h99, "R6"); rd_op(8'h80, "R6");
    wr_op(8'hFF, 8'h99, "R6"); rd_op(8'hFF, "R6");
    rd_op(8'h01, "R6"); rd_op(8'h03, "R6");

    // R7 forwarding, with bank select on 1
    wr_op(8'h04, 8'h01, "R7");
    rd_op(8'h12, "R7");
    wr_op(8'h12, 8'hE1, "R7"); rd_op(8'h12, "R7");
    wr_op(8'h03, 8'h12, "R7"); rd_op(8'h02, "R7");
    wr_op(8'h01, 8'h2F, "R7"); wr_op(8'h00, 8'h0F, "R7"); rd_op(8'h2F, "R7");
    rd_op(8'h05, "R7");

    // R9 bit set/clear
    op(8'h50, 0, 0, 8'h00, 1, 0, 3'd3, "R9"); rd_op(8'h50, "R9");
    op(8'h50, 0, 0, 8'h00, 0, 1, 3'd7, "R9"); rd_op(8'h50, "R9");
    wr_op(8'h03, 8'hF0, "R9");
    op(8'h03, 0, 0, 8'h00, 0, 1, 3'd5, "R9"); rd_op(8'h03, "R9");
    op(8'h03, 0, 0, 8'h00, 1, 1, 3'd0, "R9"); rd_op(8'h03, "R9");
    op(8'h03, 0, 1, 8'h12, 1, 0, 3'd7, "R9"); rd_op(8'h03, "R9");
    op(8'h02, 0, 0, 8'h00, 1, 0, 3'd6, "R9"); rd_op(8'h12, "R9");
    op(8'h04, 0, 0, 8'h00, 0, 1, 3'd0, "R9"); rd_op(8'h04, "R9");

    // R10 read enable gating
    op(8'h01, 0, 0, 8'h00, 0, 0, 3'd0, "R10");
    op(8'h45, 0, 0, 8'h00, 0, 0, 3'd0, "R10");
    op(8'h12, 0, 0, 8'h00, 0, 0, 3'd0, "R10");

    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 9);
      case (sel)
        0: a = 8'h00;
        1: a = 8'h02;
        2: a = 8'h01;
        3: a = 8'h03;
        4: a = 8'h04;
        5: a = 8'($urandom_range(5, 'h2F));
        6: a = 8'($urandom_range('h30, 'h3F));
        7: a = 8'($urandom_range('h80, 'hFF));
        default: a = 8'($urandom_range('h40, 'h7F));
      endcase
      op(a, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
         8'($urandom_range(0, 255)), ($urandom_range(0, 4) == 0),
         ($urandom_range(0, 4) == 0), 3'($urandom_range(0, 7)), "R10");
    end

    op(8'h00, 0, 0, 8'h00, 0, 0, 3'd0, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule